// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

This block supervises software through a restart strobe. A counter advances once per millisecond tick enable and, if software does not restart it before the programmed window runs out, the block raises its reset output. The window is chosen by a 5-bit timeout code in 100 ms steps. One code value turns the supervision off. An enable input decides whether an expiry actually drives the reset output or is only swallowed.

Once the reset output is raised, it stays high for a minimum number of ticks before it is released. A low-voltage indication from an external comparator also raises the reset. The reset stays high for as long as the indication persists, and then for the same minimum hold time. A 2-bit trip-point select is registered and handed on to that comparator model. The voltage sensing itself is outside this block.

Top module: `wdog_reset_top`

## Requirements
- R1: With timeout code N in 1..30 and the enable high, the reset output rises in the cycle after the (N × TICKS_PER_STEP)-th tick counted since the last clear, and not before.
- R2: Timeout code 0 behaves exactly like code 1 (TICKS_PER_STEP ticks).
- R3: Timeout code 31 stops the counter, so no number of ticks ever raises the reset output.
- R4: A one-cycle restart strobe clears the count, so a full new window must elapse before expiry.
- R5: Any change of the timeout code clears the count, and the new window is then counted from zero.
- R6: With the enable low, an expiry leaves the reset output low and the count restarts from zero. Raising the enable later does not clear the count.
- R7: After an expiry, the reset output stays high for HOLD_TICKS ticks and falls in the cycle after the HOLD_TICKS-th tick.
- R8: While the reset output is high, the watchdog count is held at zero, so after release a full window is needed for the next expiry.
- R9: A high low-voltage input raises the reset output in the next cycle and keeps it high for as long as the input stays high. After the input falls, the output stays high for HOLD_TICKS more ticks.
- R10: The trip-point select output equals the trip-point select input of the previous clock cycle.
- R11: After reset the reset output is low and the trip-point select output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick_ms | input | 1 | One-cycle millisecond tick enable |
| kick | input | 1 | One-cycle watchdog restart strobe from software |
| timeout_code | input | 5 | Window in 100 ms steps; 0 means one step, 31 means off |
| wd_enable | input | 1 | High: an expiry drives the reset output |
| lv_detect | input | 1 | Low-voltage indication from the comparator |
| trip_sel | input | 2 | Requested low-voltage trip point |
| cmp_trip_sel | output | 2 | Registered trip point handed to the comparator |
| reset_out | output | 1 | Active-high system reset request |

## Verification
The assertions assume that every input is synchronous to the clock. They also assume that the tick and the restart strobe are pulses one cycle wide, because the hold and release properties count a tick as one event per high cycle. The bench changes every input only at the falling clock edge. It drives each tick as a single high cycle followed by a low cycle, and raises the restart strobe for exactly one cycle between ticks. The low-voltage input and the timeout code change only between tick pulses, so each clear takes effect before the next counted tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CODE_W    = 5;
    localparam int MAX_STEPS = 30;
    typedef logic [CODE_W-1:0] wd_code_t;
    localparam wd_code_t CODE_OFF = wd_code_t'(31);
    localparam wd_code_t CODE_MIN = wd_code_t'(0);
endpackage

// File: rtl/wdog_limit_dec.sv
module wdog_limit_dec
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_STEP = 100,
    parameter int CNT_W          = 12
) (
    input  wd_code_t         code_i,
    output logic [CNT_W-1:0] limit_o,
    output logic             disabled_o
);
    logic [CNT_W-1:0] steps;

    always_comb begin
        // invalid code 0 falls back to a single step
        if (code_i == CODE_MIN) steps = CNT_W'(1);
        else                    steps = CNT_W'(code_i);
        disabled_o = (code_i == CODE_OFF);
        limit_o    = steps * CNT_W'(TICKS_PER_STEP);
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             kick_i,
    input  wd_code_t         code_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             disabled_i,
    input  logic             hold_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        wd_code_t         code;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       clear;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        st_d      = st_q;
        st_d.code = code_i;
        cnt_inc   = {1'b0, st_q.cnt} + 1'b1;
        clear     = kick_i || (code_i != st_q.code) || hold_i || disabled_i;
        expire_o  = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (cnt_inc >= {1'b0, limit_i}) begin
                expire_o = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (st_q.cnt == '0));
    p_code_change_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i != st_q.code) |=> (st_q.cnt == '0));
    p_held_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (st_q.cnt == '0));
    p_off_stays_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_i == CODE_OFF) && (st_q.code == CODE_OFF)) |-> (st_q.cnt == '0 && !expire_o));
    p_count_below_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == st_q.code) |-> (st_q.cnt < limit_i));
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
    parameter int HOLD_TICKS = 100,
    parameter int HOLD_W     = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic expire_i,
    input  logic en_i,
    input  logic lv_i,
    output logic active_o
);
    typedef struct packed {
        logic              active;
        logic [HOLD_W-1:0] hold;
    } rg_state_t;

    rg_state_t st_d, st_q;
    logic [HOLD_W:0] hold_inc;

    always_comb begin
        st_d     = st_q;
        hold_inc = {1'b0, st_q.hold} + 1'b1;
        if (lv_i) begin
            st_d.active = 1'b1;
            st_d.hold   = '0;
        end else if (expire_i && en_i) begin
            st_d.active = 1'b1;
            st_d.hold   = '0;
        end else if (st_q.active && tick_i) begin
            if (hold_inc >= (HOLD_W+1)'(HOLD_TICKS)) begin
                st_d.active = 1'b0;
                st_d.hold   = '0;
            end else begin
                st_d.hold = hold_inc[HOLD_W-1:0];
            end
        end
        active_o = st_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_lv_forces_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lv_i |=> st_q.active);
    p_expiry_asserts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && en_i) |=> st_q.active);
    p_expiry_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !lv_i && !en_i) |=> !st_q.active);
    p_release_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> ($past(tick_i) && !$past(lv_i)));
    p_hold_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold < HOLD_W'(HOLD_TICKS));
endmodule

// File: rtl/wdog_reset_top.sv
module wdog_reset_top
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_STEP = 100,
    parameter int HOLD_TICKS     = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       kick,
    input  logic [4:0] timeout_code,
    input  logic       wd_enable,
    input  logic       lv_detect,
    input  logic [1:0] trip_sel,
    output logic [1:0] cmp_trip_sel,
    output logic       reset_out
);
    localparam int CNT_W  = $clog2(MAX_STEPS * TICKS_PER_STEP + 1);
    localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

    logic [CNT_W-1:0] limit;
    logic             disabled;
    logic             expire;
    logic             active;

    typedef struct packed {
        logic [1:0] trip;
    } top_state_t;

    top_state_t st_d, st_q;

    wdog_limit_dec #(
        .TICKS_PER_STEP (TICKS_PER_STEP),
        .CNT_W          (CNT_W)
    ) i_dec (
        .code_i     (wd_code_t'(timeout_code)),
        .limit_o    (limit),
        .disabled_o (disabled)
    );

    wdog_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_ms),
        .kick_i     (kick),
        .code_i     (wd_code_t'(timeout_code)),
        .limit_i    (limit),
        .disabled_i (disabled),
        .hold_i     (active),
        .expire_o   (expire)
    );

    wdog_rst_gen #(
        .HOLD_TICKS (HOLD_TICKS),
        .HOLD_W     (HOLD_W)
    ) i_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_ms),
        .expire_i (expire),
        .en_i     (wd_enable),
        .lv_i     (lv_detect),
        .active_o (active)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trip = trip_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_trip_sel = st_q.trip;
    assign reset_out    = active;

    p_trip_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cmp_trip_sel == $past(trip_sel)));
    p_off_no_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_out && !lv_detect && timeout_code == 5'd31 && !kick) |=> !reset_out);
endmodule

// File: tb/test_wdog_reset_top.sv
module test_wdog_reset_top;
    localparam int STEP = 2;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       kick = 1'b0;
    logic [4:0] timeout_code = 5'd0;
    logic       wd_enable = 1'b1;
    logic       lv_detect = 1'b0;
    logic [1:0] trip_sel = 2'd0;
    logic [1:0] cmp_trip_sel;
    logic       reset_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_reset_top #(.TICKS_PER_STEP(STEP), .HOLD_TICKS(HOLD)) i_wdog_reset_top (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .kick(kick),
        .timeout_code(timeout_code), .wd_enable(wd_enable), .lv_detect(lv_detect),
        .trip_sel(trip_sel), .cmp_trip_sel(cmp_trip_sel), .reset_out(reset_out)
    );

    task automatic check(input int got, input int exp, input string req);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
    endtask

    task automatic pulse_kick();
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
    endtask

    task automatic set_code(input int c);
        @(negedge clk) timeout_code = 5'(c);
        @(negedge clk);
    endtask

    // from the asserted state, walk through the hold window
    task automatic check_hold(input string req);
        ticks(HOLD - 1);
        check(int'(reset_out), 1, req);
        ticks(1);
        check(int'(reset_out), 0, req);
    endtask

    initial begin
        #600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(int'(reset_out), 0, "R11");
        check(int'(cmp_trip_sel), 0, "R11");
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R7: sweep every counting code
        for (int c = 0; c <= 30; c++) begin
            int lim;
            lim = ((c == 0) ? 1 : c) * STEP;
            set_code(c);
            ticks(lim - 1);
            check(int'(reset_out), 0, (c == 0) ? "R2" : "R1");
            ticks(1);
            check(int'(reset_out), 1, (c == 0) ? "R2" : "R1");
            check_hold("R7");
        end

        // R8: count held at zero during the hold, full window afterwards
        set_code(2);
        ticks(2 * STEP);
        check(int'(reset_out), 1, "R8");
        ticks(HOLD);
        check(int'(reset_out), 0, "R8");
        ticks(2 * STEP - 1);
        check(int'(reset_out), 0, "R8");
        ticks(1);
        check(int'(reset_out), 1, "R8");
        check_hold("R8");

        // R4: restart strobe
        set_code(3);
        ticks(3 * STEP - 1);
        pulse_kick();
        ticks(3 * STEP - 1);
        check(int'(reset_out), 0, "R4");
        ticks(1);
        check(int'(reset_out), 1, "R4");
        check_hold("R4");

        // R5: code change mid-window restarts count
        set_code(4);
        ticks(4 * STEP - 1);
        set_code(5);
        ticks(5 * STEP - 1);
        check(int'(reset_out), 0, "R5");
        ticks(1);
        check(int'(reset_out), 1, "R5");
        check_hold("R5");

        // R3: code 31 never expires
        set_code(31);
        for (int k = 0; k < 8; k++) begin
            ticks(10);
            check(int'(reset_out), 0, "R3");
        end
        set_code(1);
        ticks(STEP);
        check(int'(reset_out), 1, "R3");
        check_hold("R3");

        // R6: enable low masks expiry, count restarts
        @(negedge clk) wd_enable = 1'b0;
        ticks(STEP);
        check(int'(reset_out), 0, "R6");
        ticks(STEP);
        check(int'(reset_out), 0, "R6");
        @(negedge clk) wd_enable = 1'b1;
        ticks(STEP - 1);
        check(int'(reset_out), 0, "R6");
        ticks(1);
        check(int'(reset_out), 1, "R6");
        check_hold("R6");

        // R9: low-voltage indication
        set_code(31);
        @(negedge clk) lv_detect = 1'b1;
        @(negedge clk);
        check(int'(reset_out), 1, "R9");
        ticks(HOLD + 4);
        check(int'(reset_out), 1, "R9");
        @(negedge clk) lv_detect = 1'b0;
        check_hold("R9");

        // R10: trip-point pass-through, all values
        for (int v = 0; v < 4; v++) begin
            @(negedge clk) trip_sel = 2'(v);
            @(negedge clk);
            check(int'(cmp_trip_sel), v, "R10");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule